// File: doc/BRIEF.md
# Memory-Mapped Three-Port Parallel I/O

This block gives a register bus access to twenty general-purpose lines, grouped as two byte-wide ports and one nibble-wide port. Each port has an output latch and a per-bit direction register. A set direction bit turns the matching line into a driven output: the output-enable is raised and the latched value is presented on the pad-side output. A clear direction bit leaves the line as an input. Input levels pass through a two-flop synchroniser before the bus can see them.

A write takes effect at the rising clock edge where both the select and the write strobe are high. Read data is a combinational function of the address and of registered state. For each bit, a read of a data address returns the output latch when that bit is an output and the synchronised pin level when it is an input. The direction registers cannot be read back. Reset clears every direction bit, so all lines become inputs, and leaves the output latches as they were.

Top module: `tri_port_gpio`

## Requirements
- R1: Address 0 selects the data latch of the first byte port, 1 the second byte port and 2 the nibble port. Addresses 4, 5 and 6 select the matching direction registers. A write happens at a rising edge where `bus_sel` and `bus_we` are both 1.
- R2: Each output-enable bit equals its direction bit, with 1 meaning output. Each pad-side output bit equals its output latch bit.
- R3: While `rst` is high at a rising edge, every direction bit is cleared, so all output-enables become 0. The output latches keep their values through reset.
- R4: A read of a data address returns the output latch for each bit whose direction is output, whatever level is on that pin.
- R5: A read of a data address returns the pin level for each bit whose direction is input. A pin change made between edges shows on `bus_rdata` after the second rising edge that follows it, and not after the first.
- R6: A read of any direction address (4, 5, 6) returns 8'hFF.
- R7: Bits 7 to 4 of a read of the nibble port (address 2) are always 1.
- R8: An output latch keeps its value when the direction of its bits changes. Switching a bit back to output again shows the earlier latched value.
- R9: Addresses 3 and 7 hold no register. Writes to them change nothing, and reads of them return 8'h00.
- R10: A cycle with `bus_sel` low or with `bus_we` low changes no register, whatever is on `bus_addr` and `bus_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pa_in | input | 8 | First byte port pin levels |
| pa_out | output | 8 | First byte port drive values |
| pa_oe | output | 8 | First byte port output-enables |
| pb_in | input | 8 | Second byte port pin levels |
| pb_out | output | 8 | Second byte port drive values |
| pb_oe | output | 8 | Second byte port output-enables |
| pc_in | input | 4 | Nibble port pin levels |
| pc_out | output | 4 | Nibble port drive values |
| pc_oe | output | 4 | Nibble port output-enables |

## Verification
A write becomes visible one edge after it is strobed: the next read, `pa_out` and `pa_oe` all show it. The bench therefore drives each write across exactly one rising edge and samples one time unit after the following falling edge. Reads have no latency of their own, because `bus_rdata` follows the address in the same cycle. The bench sets the address at a falling edge and compares shortly after. A pin change on an input bit is due two edges later, so the bench checks the old value after the first edge and the new value after the second.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e   kind;
        logic [1:0]  port;
    } reg_sel_t;

    // Bit 2 picks data versus direction, bits 1:0 pick the port; index 3 is empty.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.port = a[1:0];
        if (a[1:0] == 2'd3)
            s.kind = SEL_NONE;
        else if (a[2])
            s.kind = SEL_DIR;
        else
            s.kind = SEL_DATA;
        return s;
    endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/port_slice.sv
module port_slice
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_data,
    input  logic              wr_dir,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pin_i,
    output logic [W-1:0]      pin_o,
    output logic [W-1:0]      pin_oe,
    output logic [DATA_W-1:0] rd_val
);
    logic [W-1:0] out_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] pin_sync;

    // Output latch: deliberately outside reset.
    always_ff @(posedge clk) begin
        if (wr_data)
            out_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            dir_q <= '0;
        else if (wr_dir)
            dir_q <= wdata;
    end

    bit_sync #(.W(W)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    always_comb begin
        rd_val        = '1;
        rd_val[W-1:0] = (out_q & dir_q) | (pin_sync & ~dir_q);
    end

    assign pin_o  = out_q;
    assign pin_oe = dir_q;

    // Checker state: cycles since reset, saturating at 2.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)
            age_q <= '0;
        else if (age_q != 2'd2)
            age_q <= age_q + 2'd1;
    end

    assert_dir_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_dir |=> $stable(pin_oe));

    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_data |=> $stable(pin_o));

    assert_input_delay_R5: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2) |-> ((rd_val[W-1:0] & ~pin_oe) == ($past(pin_i, 2) & ~pin_oe)));

    assert_reset_clears_R3: assert property (@(posedge clk)
        rst |=> (pin_oe == '0));
endmodule

// File: rtl/tri_port_gpio.sv
module tri_port_gpio
    import gpio_pkg::*;
#(
    parameter int PA_W = 8,
    parameter int PB_W = 8,
    parameter int PC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PA_W-1:0]   pa_in,
    output logic [PA_W-1:0]   pa_out,
    output logic [PA_W-1:0]   pa_oe,
    input  logic [PB_W-1:0]   pb_in,
    output logic [PB_W-1:0]   pb_out,
    output logic [PB_W-1:0]   pb_oe,
    input  logic [PC_W-1:0]   pc_in,
    output logic [PC_W-1:0]   pc_out,
    output logic [PC_W-1:0]   pc_oe
);
    localparam int NPORTS = 3;

    reg_sel_t          sel;
    logic              wr_en;
    logic [NPORTS-1:0] wr_data_v;
    logic [NPORTS-1:0] wr_dir_v;
    logic [DATA_W-1:0] rd_a, rd_b, rd_c;

    assign sel   = decode_addr(bus_addr);
    assign wr_en = bus_sel && bus_we;

    for (genvar p = 0; p < NPORTS; p++) begin : g_strobe
        assign wr_data_v[p] = wr_en && (sel.kind == SEL_DATA) && (sel.port == 2'(p));
        assign wr_dir_v[p]  = wr_en && (sel.kind == SEL_DIR)  && (sel.port == 2'(p));
    end

    port_slice #(.W(PA_W)) u_port_a (
        .clk (clk), .rst (rst),
        .wr_data (wr_data_v[0]), .wr_dir (wr_dir_v[0]),
        .wdata (bus_wdata[PA_W-1:0]), .pin_i (pa_in),
        .pin_o (pa_out), .pin_oe (pa_oe), .rd_val (rd_a)
    );

    port_slice #(.W(PB_W)) u_port_b (
        .clk (clk), .rst (rst),
        .wr_data (wr_data_v[1]), .wr_dir (wr_dir_v[1]),
        .wdata (bus_wdata[PB_W-1:0]), .pin_i (pb_in),
        .pin_o (pb_out), .pin_oe (pb_oe), .rd_val (rd_b)
    );

    port_slice #(.W(PC_W)) u_port_c (
        .clk (clk), .rst (rst),
        .wr_data (wr_data_v[2]), .wr_dir (wr_dir_v[2]),
        .wdata (bus_wdata[PC_W-1:0]), .pin_i (pc_in),
        .pin_o (pc_out), .pin_oe (pc_oe), .rd_val (rd_c)
    );

    always_comb begin
        unique case (sel.kind)
            SEL_DATA: begin
                case (sel.port)
                    2'd0:    bus_rdata = rd_a;
                    2'd1:    bus_rdata = rd_b;
                    default: bus_rdata = rd_c;
                endcase
            end
            SEL_DIR: bus_rdata = '1;
            default: bus_rdata = '0;
        endcase
    end

    assert_out_readback_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd0) |-> ((bus_rdata & pa_oe) == (pa_out & pa_oe)));

    assert_dir_reads_ff_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[2] && bus_addr[1:0] != 2'd3) |-> (bus_rdata == 8'hFF));

    assert_nibble_upper_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd2) |-> (bus_rdata[7:4] == 4'hF));

    assert_empty_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] == 2'd3) |-> (bus_rdata == 8'h00));

    assert_oe_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] == 2'd3) |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));
endmodule

// File: tb/test_tri_port_gpio.sv
module test_tri_port_gpio;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pa_in = 8'h3C, pa_out, pa_oe;
    logic [7:0] pb_in = 8'hC3, pb_out, pb_oe;
    logic [3:0] pc_in = 4'h9, pc_out, pc_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tri_port_gpio i_tri_port_gpio (
        .clk (clk), .rst (rst), .bus_sel (bus_sel), .bus_we (bus_we),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pa_in (pa_in), .pa_out (pa_out), .pa_oe (pa_oe),
        .pb_in (pb_in), .pb_out (pb_out), .pb_oe (pb_oe),
        .pc_in (pc_in), .pc_out (pc_out), .pc_oe (pc_oe)
    );

    // {is_write, addr, data, expected read}
    localparam int NVEC = 14;
    localparam logic [19:0] VEC [0:NVEC-1] = '{
        {1'b1, 3'd0, 8'hA5, 8'h00},
        {1'b1, 3'd4, 8'h0F, 8'h00},
        {1'b0, 3'd0, 8'h00, 8'h35},  // R4 R5 mixed
        {1'b1, 3'd1, 8'h5A, 8'h00},
        {1'b1, 3'd5, 8'hF0, 8'h00},
        {1'b0, 3'd1, 8'h00, 8'h53},  // R1 R4
        {1'b1, 3'd2, 8'h06, 8'h00},
        {1'b1, 3'd6, 8'h0C, 8'h00},
        {1'b0, 3'd2, 8'h00, 8'hF5},  // R7
        {1'b0, 3'd4, 8'h00, 8'hFF},  // R6
        {1'b1, 3'd3, 8'h77, 8'h00},
        {1'b0, 3'd3, 8'h00, 8'h00},  // R9
        {1'b1, 3'd4, 8'hFF, 8'h00},
        {1'b0, 3'd0, 8'h00, 8'hA5}   // R4 all outputs
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // Reset state
        check("R3 oe after reset", {pa_oe, pb_oe, pc_oe}, 20'h0);
        bus_read(3'd0, rd); check("R5 port A input read", rd, 8'h3C);
        bus_read(3'd2, rd); check("R7 port C input read", rd, 8'hF9);
        bus_read(3'd5, rd); check("R6 dir B read", rd, 8'hFF);
        bus_read(3'd7, rd); check("R9 empty addr read", rd, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][19]) begin
                bus_write(VEC[i][18:16], VEC[i][15:8]);
            end else begin
                bus_read(VEC[i][18:16], rd);
                check($sformatf("R1 vector %0d", i), rd, VEC[i][7:0]);
            end
        end

        #1;
        check("R2 pa_oe", pa_oe, 8'hFF);
        check("R2 pb_oe", pb_oe, 8'hF0);
        check("R2 pc_oe", pc_oe, 4'hC);
        check("R2 pa_out", pa_out, 8'hA5);
        check("R2 pc_out", pc_out, 4'h6);

        // R8: direction toggles keep the latch
        bus_write(3'd4, 8'h00);
        bus_read(3'd0, rd); check("R8 A as input", rd, 8'h3C);
        check("R8 pa_out kept", pa_out, 8'hA5);

        // R5: two-edge pin latency
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 3'd0; pa_in = 8'h81;
        @(negedge clk); #1;
        check("R5 after one edge", bus_rdata, 8'h3C);
        @(negedge clk); #1;
        check("R5 after two edges", bus_rdata, 8'h81);

        bus_write(3'd4, 8'hFF);
        bus_read(3'd0, rd); check("R8 latch back", rd, 8'hA5);

        // R10: write strobe without select, select without write strobe
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h11;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 3'd4; bus_wdata = 8'h00;
        @(negedge clk);
        bus_we = 1'b0; bus_sel = 1'b0;
        #1;
        check("R10 pa_out unchanged", pa_out, 8'hA5);
        check("R10 pa_oe unchanged", pa_oe, 8'hFF);

        // R9: write to address 7 leaves the others intact
        bus_write(3'd7, 8'h00);
        #1;
        check("R9 oe after addr 7 write", {pa_oe, pb_oe, pc_oe}, {8'hFF, 8'hF0, 4'hC});

        // R3: reset clears direction, keeps latches
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        check("R3 oe cleared", {pa_oe, pb_oe, pc_oe}, 20'h0);
        check("R3 latch kept", {pa_out, pb_out, pc_out}, {8'hA5, 8'h5A, 4'h6});

        done = 1'b1;
        finish_run();
    end
endmodule